// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 9-bit words with a write port and a read port, each on its own free-running clock. The two clocks may be one net or fully unrelated. Each port is qualified by a pair of enables. One of the write pair can instead be set up, through its level while reset is held, as a strobe that loads two threshold registers. A registered read-data output can be released to a high-impedance state by an active-low output enable.

Four flags report the fill state. Empty and the programmable almost-empty flag belong to the read clock. Full and the programmable almost-full flag belong to the write clock. Each flag is computed from the local pointer and a Gray-coded copy of the far pointer that passes through a synchronizer chain. Depth is a power-of-two parameter from 64 to 8192 words.

Top module: `fifo_dc_pflag`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only when `wr_gate_n` is 0 and `wr_qual_ld` is 1. One word is stored on every edge while both hold. Any other combination stores nothing.
- R2: A word is taken on a rising `rd_clk` edge only when `rd_gate_a_n` and `rd_gate_b_n` are both 0. On that edge `rd_data` takes the oldest stored word. Words leave in the order they were stored, and a single active read enable takes nothing.
- R3: A store attempt while `full` is 1 is dropped, and the words already held are unchanged.
- R4: A read attempt while `empty` is 1 is dropped, and `rd_data` keeps its previous value.
- R5: `full` rises on the write edge that stores the DEPTH-th word. With the default two synchronizer stages, `empty` falls after the second `rd_clk` edge following the write edge of the first word (clocks tied).
- R6: `almost_empty` is 1 exactly when the stored word count is less than or equal to the almost-empty threshold.
- R7: `almost_full` is 1 exactly when the free word count (DEPTH minus stored count) is less than or equal to the almost-full threshold.
- R8: `rst_n` is asynchronous and active low. It empties the buffer, sets `empty` and `almost_empty` to 1, sets `full` and `almost_full` to 0, and clears the read-data register to 0. It sets both thresholds to 7 when DEPTH is below 512, and to 63 otherwise.
- R9: If `wr_qual_ld` is 0 while reset is held, it acts as a load strobe until the next reset. An edge with `wr_gate_n` 0 and `wr_qual_ld` 0 then copies `wr_data` (zero-extended or truncated to the count width) into a threshold register instead of storing a word. Successive loads alternate between almost-empty first and almost-full second. If `wr_qual_ld` is 1 during reset, it is a plain second write enable.
- R10: When `out_en_n` is 1, `rd_data` is high impedance and `rd_data_vld` is 0. When `out_en_n` is 0, `rd_data` shows the read-data register and `rd_data_vld` is 1.
- R11: Reads and writes on the same edge both take effect. The stored count is unchanged and word order is preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_gate_n | input | 1 | Write enable, active low |
| wr_qual_ld | input | 1 | Second write enable (active high) or threshold load strobe (active low), chosen at reset |
| wr_data | input | 9 | Word to store, or threshold value to load |
| rd_gate_a_n | input | 1 | First read enable, active low |
| rd_gate_b_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output enable for `rd_data`, active low |
| rd_data | output | 9 | Read-data register, high impedance when disabled |
| rd_data_vld | output | 1 | 1 when `rd_data` is driven |
| empty | output | 1 | No words held (read domain) |
| almost_empty | output | 1 | Count at or below almost-empty threshold (read domain) |
| almost_full | output | 1 | Free space at or below almost-full threshold (write domain) |
| full | output | 1 | DEPTH words held (write domain) |

## Verification
Read data is due on the same read edge that accepts the read, so the bench samples `rd_data` one nanosecond after that edge. `full` and `almost_full` follow the write edge at once. `empty` and `almost_empty` only see a write after the two-stage synchronizer has passed it, which is two edges later. The bench probes that delay cycle by cycle once. Every other flag comparison waits four idle cycles after the last stimulus, which covers the longest path through the synchronizers. The output-enable result is combinational and is sampled shortly after the input changes.

// File: rtl/fifo_dc_pflag_pkg.sv
package fifo_dc_pflag_pkg;

   localparam int DATA_W    = 9;
   localparam int MIN_DEPTH = 64;
   localparam int MAX_DEPTH = 8192;
   localparam int PTR_MAX_W = 14;

   typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} thr_sel_e;

   function automatic int default_threshold(input int depth);
      return (depth >= 512) ? 63 : 7;
   endfunction

   function automatic logic [PTR_MAX_W-1:0] bin_to_gray(input logic [PTR_MAX_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PTR_MAX_W-1:0] gray_to_bin(input logic [PTR_MAX_W-1:0] g);
      logic [PTR_MAX_W-1:0] b;
      b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
      for (int i = PTR_MAX_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

endpackage

// File: rtl/fifo_dc_pflag_sync.sv
module fifo_dc_pflag_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_dc_pflag_mem.sv
module fifo_dc_pflag_mem #(
   parameter int DW    = 9,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] ram [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) ram[waddr] <= wdata;
   end

   assign rdata = ram[raddr];
endmodule

// File: rtl/fifo_dc_pflag_wr.sv
module fifo_dc_pflag_wr
   import fifo_dc_pflag_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_n,
   input  logic              qual_ld,
   input  logic [DATA_W-1:0] din,
   input  logic [CW-1:0]     rd_gray_s,
   output logic [CW-1:0]     wr_gray,
   output logic              mem_we,
   output logic [AW-1:0]     mem_waddr,
   output logic              full,
   output logic              almost_full,
   output logic [CW-1:0]     ae_thr,
   output logic [CW-1:0]     af_thr
);
   localparam logic [CW-1:0] DEF_THR = CW'(default_threshold(DEPTH));
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic           ld_mode;
   thr_sel_e       sel;
   logic [CW-1:0]  wr_bin, wr_bin_nx, rd_bin_s, used, free_cnt;
   logic           wr_req, ld_req, wr_fire;

   assign wr_req    = !gate_n && qual_ld;
   assign ld_req    = ld_mode && !gate_n && !qual_ld;
   assign wr_fire   = wr_req && !full;
   assign wr_bin_nx = wr_bin + CW'(1);

   assign rd_bin_s    = CW'(gray_to_bin(PTR_MAX_W'(rd_gray_s)));
   assign used        = wr_bin - rd_bin_s;
   assign free_cnt    = DEPTH_C - used;
   assign full        = (used == DEPTH_C);
   assign almost_full = (free_cnt <= af_thr);

   assign mem_we    = wr_fire;
   assign mem_waddr = wr_bin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else if (wr_fire) begin
         wr_bin  <= wr_bin_nx;
         wr_gray <= CW'(bin_to_gray(PTR_MAX_W'(wr_bin_nx)));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_mode <= !qual_ld;
         sel     <= SEL_AE;
         ae_thr  <= DEF_THR;
         af_thr  <= DEF_THR;
      end else if (ld_req) begin
         if (sel == SEL_AE) begin
            ae_thr <= CW'(din);
            sel    <= SEL_AF;
         end else begin
            af_thr <= CW'(din);
            sel    <= SEL_AE;
         end
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full) |=> $stable(wr_bin));
   p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wr_bin == $past(wr_bin)) || (wr_bin == $past(wr_bin) + CW'(1)));
   p_gray_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $onehot0(wr_gray ^ $past(wr_gray)));
   p_full_af_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> almost_full);
   p_load_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |=> $stable(wr_bin));
endmodule

// File: rtl/fifo_dc_pflag_rd.sv
module fifo_dc_pflag_rd
   import fifo_dc_pflag_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_a_n,
   input  logic              gate_b_n,
   input  logic [CW-1:0]     wr_gray_s,
   input  logic [CW-1:0]     ae_thr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [AW-1:0]     mem_raddr,
   output logic [CW-1:0]     rd_gray,
   output logic [DATA_W-1:0] dout_q,
   output logic              empty,
   output logic              almost_empty
);
   logic [CW-1:0] rd_bin, rd_bin_nx, wr_bin_s, used;
   logic          rd_req, rd_fire;

   assign rd_req    = !gate_a_n && !gate_b_n;
   assign rd_fire   = rd_req && !empty;
   assign rd_bin_nx = rd_bin + CW'(1);

   assign wr_bin_s     = CW'(gray_to_bin(PTR_MAX_W'(wr_gray_s)));
   assign used         = wr_bin_s - rd_bin;
   assign empty        = (used == '0);
   assign almost_empty = (used <= ae_thr);
   assign mem_raddr    = rd_bin[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
         dout_q  <= '0;
      end else if (rd_fire) begin
         rd_bin  <= rd_bin_nx;
         rd_gray <= CW'(bin_to_gray(PTR_MAX_W'(rd_bin_nx)));
         dout_q  <= mem_rdata;
      end
   end

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty) |=> ($stable(rd_bin) && $stable(dout_q)));
   p_empty_ae_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> almost_empty);
   p_rptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

// File: rtl/fifo_dc_pflag.sv
module fifo_dc_pflag
   import fifo_dc_pflag_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_gate_n,
   input  logic              wr_qual_ld,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_gate_a_n,
   input  logic              rd_gate_b_n,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_data_vld,
   output logic              empty,
   output logic              almost_empty,
   output logic              almost_full,
   output logic              full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fifo_dc_pflag: DEPTH must be a power of two from 64 to 8192");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fifo_dc_pflag: SYNC_STAGES must be at least 2");
   end
   if (CW > PTR_MAX_W) begin : g_bad_ptr
      $error("fifo_dc_pflag: pointer wider than package limit");
   end

   logic [CW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s, ae_thr, af_thr;
   logic              mem_we;
   logic [AW-1:0]     mem_waddr, mem_raddr;
   logic [DATA_W-1:0] mem_rdata, dout_q;

   fifo_dc_pflag_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s));

   fifo_dc_pflag_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s));

   fifo_dc_pflag_mem #(.DW(DATA_W), .DEPTH(DEPTH)) u_mem (
      .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
      .raddr(mem_raddr), .rdata(mem_rdata));

   fifo_dc_pflag_wr #(.DEPTH(DEPTH)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .gate_n(wr_gate_n), .qual_ld(wr_qual_ld),
      .din(wr_data), .rd_gray_s(rd_gray_s), .wr_gray(wr_gray),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .full(full),
      .almost_full(almost_full), .ae_thr(ae_thr), .af_thr(af_thr));

   fifo_dc_pflag_rd #(.DEPTH(DEPTH)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .gate_a_n(rd_gate_a_n), .gate_b_n(rd_gate_b_n),
      .wr_gray_s(wr_gray_s), .ae_thr(ae_thr), .mem_rdata(mem_rdata),
      .mem_raddr(mem_raddr), .rd_gray(rd_gray), .dout_q(dout_q),
      .empty(empty), .almost_empty(almost_empty));

   assign rd_data_vld = !out_en_n;
   assign rd_data     = out_en_n ? {DATA_W{1'bz}} : dout_q;

   p_reset_flags_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (empty && almost_empty));
endmodule

// File: tb/tb_fifo_dc_pflag.sv
module tb_fifo_dc_pflag;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_gate_n = 1'b1, wr_qual_ld = 1'b1;
   logic [8:0] wr_data = '0;
   logic       rd_gate_a_n = 1'b1, rd_gate_b_n = 1'b1, out_en_n = 1'b0;
   logic [8:0] rd_data;
   logic       rd_data_vld, empty, almost_empty, almost_full, full;

   int n_chk = 0, n_bad = 0;
   int lvl = 0, wseq = 0, rseq = 0;
   logic [8:0] last_rd = '0;
   bit done = 0;

   always #5 clk = ~clk;

   fifo_dc_pflag #(.DEPTH(DEPTH)) dut (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
      .wr_gate_n(wr_gate_n), .wr_qual_ld(wr_qual_ld), .wr_data(wr_data),
      .rd_gate_a_n(rd_gate_a_n), .rd_gate_b_n(rd_gate_b_n), .out_en_n(out_en_n),
      .rd_data(rd_data), .rd_data_vld(rd_data_vld), .empty(empty),
      .almost_empty(almost_empty), .almost_full(almost_full), .full(full));

   // {writes, reads, empty, almost_empty, almost_full, full}; thresholds 7/7
   localparam logic [19:0] VEC [11] = '{
      {8'd1,  8'd0,  4'b0100},
      {8'd6,  8'd0,  4'b0100},
      {8'd1,  8'd0,  4'b0000},
      {8'd48, 8'd0,  4'b0000},
      {8'd1,  8'd0,  4'b0010},
      {8'd7,  8'd0,  4'b0011},
      {8'd3,  8'd0,  4'b0011},
      {8'd0,  8'd1,  4'b0010},
      {8'd0,  8'd56, 4'b0100},
      {8'd0,  8'd7,  4'b1100},
      {8'd0,  8'd2,  4'b1100}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_flags(input string req, input logic [3:0] exp);
      check(req, {28'd0, empty, almost_empty, almost_full, full}, {28'd0, exp});
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset(input logic qual);
      @(negedge clk);
      wr_qual_ld = qual; wr_gate_n = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wr_qual_ld = 1'b1;
      lvl = 0; rseq = wseq; last_rd = '0;
   endtask

   task automatic wr_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_gate_n = 1'b0; wr_qual_ld = 1'b1;
         wr_data = (lvl < DEPTH) ? wseq[8:0] : 9'h1AA;
         @(posedge clk);
         if (lvl < DEPTH) begin lvl++; wseq++; end
      end
      @(negedge clk);
      wr_gate_n = 1'b1;
   endtask

   task automatic rd_n(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_gate_a_n = 1'b0; rd_gate_b_n = 1'b0;
         @(posedge clk);
         if (lvl > 0) begin last_rd = rseq[8:0]; rseq++; lvl--; end
         #1 check(req, {23'd0, rd_data}, {23'd0, last_rd});
      end
      @(negedge clk);
      rd_gate_a_n = 1'b1; rd_gate_b_n = 1'b1;
   endtask

   task automatic rw_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rd_gate_a_n = 1'b0; rd_gate_b_n = 1'b0;
         wr_gate_n = 1'b0; wr_qual_ld = 1'b1; wr_data = wseq[8:0];
         @(posedge clk);
         last_rd = rseq[8:0]; rseq++; wseq++;
         #1 check("R11 simultaneous order", {23'd0, rd_data}, {23'd0, last_rd});
      end
      @(negedge clk);
      rd_gate_a_n = 1'b1; rd_gate_b_n = 1'b1; wr_gate_n = 1'b1;
   endtask

   task automatic load_thr(input logic [8:0] v);
      @(negedge clk);
      wr_gate_n = 1'b0; wr_qual_ld = 1'b0; wr_data = v;
      @(negedge clk);
      wr_gate_n = 1'b1; wr_qual_ld = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // Phase 1: second write enable mode
      do_reset(1'b1);
      chk_flags("R8 reset flags", 4'b1100);
      check("R8 reset read data", {23'd0, rd_data}, 32'd0);
      check("R10 valid when enabled", {31'd0, rd_data_vld}, 32'd1);

      // R1: partial qualifications store nothing
      @(negedge clk); wr_gate_n = 1'b0; wr_qual_ld = 1'b0;
      repeat (3) @(negedge clk);
      wr_gate_n = 1'b1; wr_qual_ld = 1'b1;
      repeat (3) @(negedge clk);
      settle();
      chk_flags("R1 no store on partial enable", 4'b1100);

      foreach (VEC[k]) begin
         wr_n(int'(VEC[k][19:12]));
         if (VEC[k][0]) check("R5 full same edge", {31'd0, full}, 32'd1);
         rd_n(int'(VEC[k][11:4]), (k == 10) ? "R4 underflow hold" : "R2 read order R3 intact");
         settle();
         chk_flags((k < 6) ? "R6 R7 fill flags" : "R3 R4 R6 R7 drain flags", VEC[k][3:0]);
      end

      // R5: empty deasserts after two read-clock edges
      @(negedge clk);
      wr_gate_n = 1'b0; wr_data = wseq[8:0];
      @(negedge clk);
      wr_gate_n = 1'b1; lvl++; wseq++;
      check("R5 empty after edge 0", {31'd0, empty}, 32'd1);
      @(negedge clk);
      check("R5 empty after edge 1", {31'd0, empty}, 32'd1);
      @(negedge clk);
      check("R5 empty after edge 2", {31'd0, empty}, 32'd0);

      // R2: a single read enable takes nothing
      @(negedge clk); rd_gate_a_n = 1'b0;
      repeat (3) @(negedge clk);
      rd_gate_a_n = 1'b1; rd_gate_b_n = 1'b0;
      repeat (3) @(negedge clk);
      rd_gate_b_n = 1'b1;
      settle();
      check("R2 single enable no read", {31'd0, empty}, 32'd0);
      check("R2 single enable data held", {23'd0, rd_data}, {23'd0, last_rd});
      rd_n(1, "R2 read after single enable");
      settle();
      chk_flags("R2 drained", 4'b1100);

      // R11: simultaneous read and write
      wr_n(10);
      settle();
      rw_n(20);
      settle();
      chk_flags("R11 level kept", 4'b0000);
      rd_n(10, "R11 drain order");
      settle();
      chk_flags("R11 empty again", 4'b1100);

      // R10: output enable
      @(negedge clk); out_en_n = 1'b1; #1;
      check("R10 high impedance", {31'd0, (rd_data === 9'bz)}, 32'd1);
      check("R10 valid low", {31'd0, rd_data_vld}, 32'd0);
      @(negedge clk); out_en_n = 1'b0; #1;
      check("R10 restored data", {23'd0, rd_data}, {23'd0, last_rd});

      // Phase 2: load strobe mode
      do_reset(1'b0);
      chk_flags("R8 reset flags load mode", 4'b1100);
      load_thr(9'd3);
      load_thr(9'd5);
      settle();
      chk_flags("R9 load stores no word", 4'b1100);
      wr_n(3); settle();
      chk_flags("R9 ae threshold 3 at level 3", 4'b0100);
      wr_n(1); settle();
      chk_flags("R9 ae threshold 3 at level 4", 4'b0000);
      load_thr(9'd10); settle();
      chk_flags("R9 third load returns to ae", 4'b0100);
      wr_n(54); settle();
      chk_flags("R9 af threshold 5 at level 58", 4'b0000);
      wr_n(1); settle();
      chk_flags("R9 af threshold 5 at level 59", 4'b0010);
      rd_n(59, "R9 data intact after loads");
      settle();
      chk_flags("R9 drained", 4'b1100);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule